// File: doc/BRIEF.md
# Pipelined Inner-Product Unit

This block forms the signed dot product of two vectors of `N` fixed-point elements. All `N` element products are formed in parallel. A balanced binary adder tree then reduces them, one registered level at a time. The unit is fully pipelined, so it accepts a new pair of vectors on every clock cycle and never stalls.

An iterative linear solver shares this one unit between two kinds of work:

- **Matrix-vector multiply.** The solver streams the rows of a matrix against a fixed vector, one row per cycle. The `N` consecutive results are the elements of the product vector.
- **Scalar reductions.** The solver also slots in single reductions, such as a residual norm squared or a direction-times-product term. Each of these takes one input slot.

A sideband tag travels with every vector pair, so results from interleaved problems and operations can be told apart at the output. The tag would typically carry a problem index and an operation code.

The unit uses `N` multipliers and `N-1` adders. When `N` is not a power of two, the tree is padded up to the next power of two with zero leaves.

Top module: `dotp_unit`

## Requirements
- R1: With `in_valid` high, `out_sum` equals the exact signed two's complement sum of `a_i*b_i` over all lanes. Element `i` of each vector occupies bits `[i*DW +: DW]` of `vec_a` and `vec_b`.
- R2: A vector pair sampled at a clock edge produces its result, with `out_valid` high, after exactly `LAT = LM + LS*ceil(log2 N)` rising edges, counting the sampling edge. With the defaults `LM=2`, `LS=1`, `N=5`, this gives `LAT=5`.
- R3: A valid pair may be presented on every cycle back to back. Each pair yields its own result, in input order, one per cycle. Streaming `N` matrix rows against one vector yields the `N` product elements on consecutive cycles.
- R4: The `in_tag` presented with a pair appears unchanged on `out_tag` in the same cycle as that pair's result.
- R5: While `out_valid` is low, `out_sum` and `out_tag` read zero, whatever data was presented with `in_valid` low.
- R6: The result width is `2*DW + ceil(log2 N)` bits, and no operand values overflow it. All lanes at the most negative value times the most negative value give the exact positive sum.
- R7: For `N` not a power of two, the padding leaves contribute nothing. A single nonzero lane in the highest position yields exactly that lane's product.
- R8: A synchronous active-low reset discards every pair in flight. `out_valid` stays low from the reset edge until a pair sampled after reset has completed its `LAT` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The vector pair on this cycle is to be reduced |
| in_tag | input | TW | Sideband label carried with the pair |
| vec_a | input | N*DW | First operand vector, element i at bits [i*DW +: DW] |
| vec_b | input | N*DW | Second operand vector, same packing |
| out_valid | output | 1 | `out_sum` and `out_tag` carry a result |
| out_tag | output | TW | Label of the pair whose result is shown, zero when idle |
| out_sum | output | 2*DW+ceil(log2 N) | Signed dot product, zero when idle |

## Verification
The bench goes after four hazards:

- **Off-by-one latency.** A wrong count of register stages would shift every result by a cycle against its tag. A single isolated pair exposes this directly.
- **Arithmetic width.** All-most-negative operands expose a tree that does not widen enough, or a product that is sign-extended wrongly. Such a design would wrap to a negative or truncated sum.
- **Padding.** A lone nonzero value in the top lane, with `N=5` as the default, catches a padded tree that reads garbage or drops the last real leaf.
- **Reset and idle cycles.** A mid-stream reset and long runs with `in_valid` low catch stale results leaking out. They also catch tags misaligned with their sums and nonzero data shown while idle.

// File: rtl/dotp_pkg.sv
// Shared helpers for the inner-product unit.
// Assumes the vector order passed in is at least 1.
package dotp_pkg;

    // Number of adder-tree levels needed to reduce n leaves to one word.
    function automatic int tree_depth(input int n);
        int d;
        d = 0;
        for (int i = 0; i < 31; i++) begin
            if ((1 << i) < n) d = i + 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/dotp_delay.sv
// Fixed-depth register shift line with synchronous active-low clear.
// Assumes D >= 1. Used for multiplier, adder and sideband pipelining.
module dotp_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [D];

    // Shift the word one stage per cycle; clear all stages on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) stage[i] <= '0;
        end else begin
            stage[0] <= din;
            for (int i = 1; i < D; i++) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[D-1];

endmodule

// File: rtl/dotp_mul_bank.sv
// N parallel signed multipliers, each followed by LM register stages.
// Products are full double width, so no product is ever truncated.
// Assumes LM >= 1 and DW >= 2.
module dotp_mul_bank #(
    parameter int N  = 5,
    parameter int DW = 12,
    parameter int LM = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N*DW-1:0]      vec_a,
    input  logic [N*DW-1:0]      vec_b,
    output logic [N*2*DW-1:0]    prod
);

    localparam int PW = 2 * DW;

    logic [N*PW-1:0] raw;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic signed [DW-1:0] op_a;
        logic signed [DW-1:0] op_b;
        logic signed [PW-1:0] p;
        assign op_a = vec_a[i*DW +: DW];
        assign op_b = vec_b[i*DW +: DW];
        // Full-width signed product of one lane.
        assign p = PW'(op_a) * PW'(op_b);
        assign raw[i*PW +: PW] = p;
    end

    dotp_delay #(.W(N*PW), .D(LM)) u_mul_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (prod)
    );

    localparam logic signed [PW-1:0] PLIM = {2'b01, {(PW-2){1'b0}}};

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6: a registered product never exceeds the range of a DW x DW signed multiply.
        a_r6_product_range: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(prod[i*PW +: PW]) <= PLIM) && ($signed(prod[i*PW +: PW]) >= -PLIM));
    end

endmodule

// File: rtl/dotp_add_level.sv
// One level of the reduction tree: CNT words in, CNT/2 pairwise sums out,
// then LS register stages. Words travel in RW-bit slots. Inputs are
// significant only in their low IW bits; outputs are IW+1 bits, sign-extended.
// Assumes CNT is even and IW < RW.
module dotp_add_level #(
    parameter int CNT = 8,
    parameter int IW  = 24,
    parameter int RW  = 27,
    parameter int LS  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT*RW-1:0]         din,
    output logic [(CNT/2)*RW-1:0]     dout
);

    localparam int OW   = IW + 1;
    localparam int HALF = CNT / 2;

    logic [HALF*RW-1:0] sums;

    for (genvar j = 0; j < HALF; j++) begin : g_pair
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [OW-1:0] s;
        assign x = din[(2*j)*RW +: IW];
        assign y = din[(2*j+1)*RW +: IW];
        // Add one pair, one bit wider than the operands.
        assign s = OW'(x) + OW'(y);
        assign sums[j*RW +: RW] = RW'(s);

        // R6: each incoming slot is a sign extension of its IW-bit value.
        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (din[(2*j)*RW +: RW] == RW'(x)) && (din[(2*j+1)*RW +: RW] == RW'(y)));
    end

    dotp_delay #(.W(HALF*RW), .D(LS)) u_add_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sums),
        .dout (dout)
    );

endmodule

// File: rtl/dotp_unit.sv
// Fully unrolled pipelined inner-product unit.
// N multipliers feed a balanced adder tree that is zero-padded to a power of two.
// A valid bit and tag ride a shift line of matching depth.
// One pair is accepted per cycle; the result appears LM + LS*ceil(log2 N)
// edges later. Assumes N >= 2, LM >= 1, LS >= 1.
module dotp_unit
    import dotp_pkg::*;
#(
    parameter int N  = 5,
    parameter int DW = 12,
    parameter int LM = 2,
    parameter int LS = 1,
    parameter int TW = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [TW-1:0]                      in_tag,
    input  logic [N*DW-1:0]                    vec_a,
    input  logic [N*DW-1:0]                    vec_b,
    output logic                               out_valid,
    output logic [TW-1:0]                      out_tag,
    output logic [2*DW+tree_depth(N)-1:0]      out_sum
);

    localparam int LEVELS = tree_depth(N);
    localparam int LEAVES = 1 << LEVELS;
    localparam int PW     = 2 * DW;
    localparam int RW     = PW + LEVELS;
    localparam int LAT    = LM + LS * LEVELS;
    localparam int CW     = $clog2(LAT + 1) + 1;

    // Triangular tree storage: level l starts at word 2*LEAVES - 2*(LEAVES >> l).
    logic [N*PW-1:0]            prod;
    logic [(2*LEAVES-1)*RW-1:0] tree;
    logic [RW-1:0]              final_sum;
    logic [TW:0]                side_in;
    logic [TW:0]                side_out;

    dotp_mul_bank #(.N(N), .DW(DW), .LM(LM)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .vec_a(vec_a),
        .vec_b(vec_b),
        .prod (prod)
    );

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign tree[i*RW +: RW] = RW'($signed(prod[i*PW +: PW]));
        end else begin : g_pad
            assign tree[i*RW +: RW] = '0;
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        localparam int CNT  = LEAVES >> l;
        localparam int IOFF = 2 * LEAVES - 2 * CNT;
        localparam int OOFF = 2 * LEAVES - CNT;
        dotp_add_level #(.CNT(CNT), .IW(PW + l), .RW(RW), .LS(LS)) u_lvl (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (tree[IOFF*RW +: CNT*RW]),
            .dout (tree[OOFF*RW +: (CNT/2)*RW])
        );
    end

    assign final_sum = tree[(2*LEAVES-2)*RW +: RW];

    // Valid bit and tag delayed to line up with the arithmetic.
    assign side_in = {in_valid, in_tag};

    dotp_delay #(.W(TW+1), .D(LAT)) u_side (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (side_in),
        .dout (side_out)
    );

    assign out_valid = side_out[TW];
    assign out_tag   = side_out[TW] ? side_out[TW-1:0] : '0;
    assign out_sum   = side_out[TW] ? final_sum : '0;

    // Pairs accepted but not yet delivered; feeds the checks below only.
    logic [CW-1:0] inflight;

    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + CW'(in_valid) - CW'(out_valid);
    end

    // R2: never more pairs outstanding than the pipeline has stages.
    a_r2_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(LAT));

    // R4: every delivered result belongs to an accepted pair.
    a_r4_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

endmodule

// File: tb/dotp_unit_tb.sv
`timescale 1ns/1ps
module dotp_unit_tb;

    localparam int N      = 5;
    localparam int DW     = 12;
    localparam int LM     = 2;
    localparam int LS     = 1;
    localparam int TW     = 6;
    localparam int LEVELS = $clog2(N);
    localparam int RW     = 2 * DW + LEVELS;
    localparam int LAT    = LM + LS * LEVELS;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [TW-1:0]     in_tag;
    logic [N*DW-1:0]   vec_a;
    logic [N*DW-1:0]   vec_b;
    logic              out_valid;
    logic [TW-1:0]     out_tag;
    logic [RW-1:0]     out_sum;

    int n_checks = 0;
    int n_errs   = 0;
    bit model_on = 1'b0;
    string cur_req = "R8";

    typedef struct {
        bit            v;
        logic [TW-1:0] t;
        longint        s;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    dotp_unit #(.N(N), .DW(DW), .LM(LM), .LS(LS), .TW(TW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .vec_a    (vec_a),
        .vec_b    (vec_b),
        .out_valid(out_valid),
        .out_tag  (out_tag),
        .out_sum  (out_sum)
    );

    function automatic longint ref_dot(input logic [N*DW-1:0] a, input logic [N*DW-1:0] b);
        longint s;
        s = 0;
        for (int i = 0; i < N; i++) begin
            s += longint'($signed(a[i*DW +: DW])) * longint'($signed(b[i*DW +: DW]));
        end
        return s;
    endfunction

    function automatic logic [N*DW-1:0] rand_vec();
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = DW'($urandom);
        return v;
    endfunction

    function automatic logic [N*DW-1:0] fill_vec(input logic [DW-1:0] e);
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = e;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [TW-1:0] t,
                         input logic [N*DW-1:0] a, input logic [N*DW-1:0] b);
        @(negedge clk);
        in_valid = v;
        in_tag   = t;
        vec_a    = a;
        vec_b    = b;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) drive(1'b0, '0, '0, '0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // Behavioural reference: one entry per edge, the oldest of LAT is on show.
    always @(posedge clk) begin
        exp_t e;
        if (!rst_n) begin
            q.delete();
            e.v = 1'b0; e.t = '0; e.s = 0;
        end else begin
            e.v = in_valid;
            e.t = in_valid ? in_tag : '0;
            e.s = in_valid ? ref_dot(vec_a, vec_b) : 0;
        end
        q.push_back(e);
        if (q.size() > LAT) q.pop_front();
    end

    // Compare every output against the reference, away from the rising edge.
    always @(negedge clk) begin
        exp_t e;
        longint got;
        if (model_on) begin
            if (q.size() == LAT) e = q[0];
            else begin e.v = 1'b0; e.t = '0; e.s = 0; end
            got = longint'($signed(out_sum));
            chk(out_valid == e.v, cur_req, "out_valid", longint'(out_valid), longint'(e.v));
            chk(out_tag == e.t, cur_req, "out_tag", longint'(out_tag), longint'(e.t));
            chk(got == e.s, cur_req, "out_sum", got, e.s);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errs++;
        $display("FAIL R3 watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        logic [N*DW-1:0] bv;
        rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; vec_a = '0; vec_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R8: reset state, nothing valid.
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", "out_valid after reset", longint'(out_valid), 0);
        end

        // R2: isolated pair, count edges to its result.
        cur_req = "R2";
        drive(1'b1, 6'd9, rand_vec(), rand_vec());
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        while (!out_valid && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LAT, "R2", "latency in cycles", cnt, LAT);
        idle(LAT);

        // R1, R3, R4: back-to-back random pairs with distinct tags.
        cur_req = "R3";
        for (int i = 0; i < 40; i++) drive(1'b1, TW'(i), rand_vec(), rand_vec());
        idle(LAT);

        // R3: matrix rows streamed against one vector.
        bv = rand_vec();
        for (int i = 0; i < N; i++) drive(1'b1, TW'(32 + i), rand_vec(), bv);
        idle(LAT);

        // R6: extreme operands.
        cur_req = "R6";
        drive(1'b1, 6'd1, fill_vec(12'h800), fill_vec(12'h800));
        drive(1'b1, 6'd2, fill_vec(12'h800), fill_vec(12'h7FF));
        drive(1'b1, 6'd3, fill_vec(12'h7FF), fill_vec(12'h7FF));
        idle(LAT);

        // R7: only the highest real lane is nonzero.
        cur_req = "R7";
        drive(1'b1, 6'd4, {12'd7, {(N-1)*DW{1'b0}}}, {12'hFFD, {(N-1)*DW{1'b0}}});
        drive(1'b1, 6'd5, fill_vec(12'd1), fill_vec(12'd1));
        idle(LAT);

        // R5: nonzero data with valid low must show nothing.
        cur_req = "R5";
        for (int i = 0; i < 10; i++) begin
            drive(1'b0, 6'h3F, rand_vec(), rand_vec());
            chk(out_sum == '0 && out_tag == '0, "R5", "idle outputs nonzero",
                longint'(out_sum), 0);
        end

        // R8: reset while pairs are in flight.
        cur_req = "R8";
        for (int i = 0; i < 3; i++) drive(1'b1, TW'(50 + i), rand_vec(), rand_vec());
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", "result leaked past reset", longint'(out_valid), 0);
        end

        // R4: random mix of valid and idle slots.
        cur_req = "R4";
        for (int i = 0; i < 300; i++) drive(1'($urandom), TW'($urandom), rand_vec(), rand_vec());
        idle(LAT + 2);

        model_on = 1'b0;
        summary();
        $finish;
    end

endmodule